// File: doc/BRIEF.md
# Sideband Command Controller Register Stub

This block presents the software-visible register face of a sideband management command controller while doing no signalling at all. Software programs it over a plain 32-bit register bus: one address, a write strobe, write data, and combinational read data. Every command that software fires completes on the next clock edge. The completion code for success (0x40) is placed in the first word of both the transmit buffer and the receive buffer. Command completion is reported through a write-one-to-clear status register and a level interrupt.

The remaining words of the 16-word space are plain 32-bit storage, which includes the interrupt enable word. Software that expects a real controller can therefore write its setup values and read them back. When a fire is attempted before the previous completion has been acknowledged, the fire is refused. The refusal is reported as a one-cycle error pulse, and the register contents do not change.

Top module: `sbcmd_regs`

## Requirements
- R1: The command word (byte offset 0x08) stores nothing and always reads 0. Its bit 0 is the fire control.
- R2: A write to the command word with bit 0 clear changes no register, leaves the interrupt output as it was, and raises no error pulse.
- R3: An accepted fire is a write to 0x08 with bit 0 set while the status word (0x1C) is zero. From the next cycle on, the words at 0x20 and 0x30 both read 0x40.
- R4: On an accepted fire, the status word becomes the enable word (0x18) ANDed with 1, where bit 0 means command done. The interrupt output is high from the next cycle only if that result is nonzero.
- R5: A write to 0x1C clears each status bit whose write-data bit is 1 and keeps the others. When the status becomes zero, the interrupt output goes low in the next cycle.
- R6: A fire while the status word is nonzero changes no register. It drives the error output high for exactly the cycle after the write.
- R7: Byte addresses at or above 0x40 read as 0, and writes to them change nothing.
- R8: A write to any in-range offset other than 0x08 and 0x1C stores the full 32-bit word. Address bits 1:0 are ignored.
- R9: After reset, every word reads 0 and both outputs are low.
- R10: The interrupt output is a level that stays high for as long as the status word is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W (8) | Byte address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| irq_o | output | 1 | Completion interrupt level |
| proto_err_o | output | 1 | One-cycle pulse when a fire is refused |

## Verification
Fires are tried in three conditions: with the enable bit clear, with it set, and while a previous completion is still pending. These separate the buffer loading, the masked status latch and the refusal path. Status clears are driven with all-zero, partial and full masks, which shows that only the written ones drop the interrupt. Random traffic covers every word index, with nonzero low address bits and out-of-range addresses mixed in. Each access is followed by a read-back against a bench model of the map, so a stray store, a wrong alias or a missed guard shows up as a mismatch.

// File: rtl/sbcmd_pkg.sv
package sbcmd_pkg;
    localparam int unsigned DW        = 32;
    // word indices whose placement software depends on
    localparam int unsigned W_CMD     = 2;
    localparam int unsigned W_EN      = 6;
    localparam int unsigned W_STS     = 7;
    localparam int unsigned W_TXBUF   = 8;
    localparam int unsigned W_RXBUF   = 12;
    localparam logic [DW-1:0] DONE_CODE = 32'h0000_0040;
    localparam logic [DW-1:0] DONE_MASK = 32'h0000_0001;

    typedef struct packed {
        logic irq;
        logic err;
    } ctl_t;
endpackage

// File: rtl/sbcmd_decode.sv
module sbcmd_decode #(
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned NUM_WORDS = 16,
    localparam int unsigned IDX_W    = $clog2(NUM_WORDS)
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [IDX_W-1:0]  idx,
    output logic              in_range,
    output logic              is_cmd,
    output logic              is_sts
);
    localparam int unsigned WA_W = ADDR_W - 2;
    // NUM_WORDS must be representable in WA_W bits
    localparam logic [WA_W-1:0] LIMIT = WA_W'(NUM_WORDS);

    logic [WA_W-1:0] word;

    always_comb begin
        word     = addr[ADDR_W-1:2];
        in_range = word < LIMIT;
        idx      = word[IDX_W-1:0];
        is_cmd   = in_range && (idx == IDX_W'(sbcmd_pkg::W_CMD));
        is_sts   = in_range && (idx == IDX_W'(sbcmd_pkg::W_STS));
    end
endmodule

// File: rtl/sbcmd_fire.sv
module sbcmd_fire (
    input  logic we,
    input  logic hit_cmd,
    input  logic fire_bit,
    input  logic pending,
    output logic accept,
    output logic reject
);
    logic attempt;

    always_comb begin
        attempt = we && hit_cmd && fire_bit;
        accept  = attempt && !pending;
        reject  = attempt && pending;
    end
endmodule

// File: rtl/sbcmd_regs.sv
module sbcmd_regs #(
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned NUM_WORDS = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic                     bus_we,
    input  logic [sbcmd_pkg::DW-1:0] bus_wdata,
    output logic [sbcmd_pkg::DW-1:0] bus_rdata,
    output logic                     irq_o,
    output logic                     proto_err_o
);
    import sbcmd_pkg::*;

    localparam int unsigned IDX_W = $clog2(NUM_WORDS);

    logic [DW-1:0] regs_q [NUM_WORDS];
    logic [DW-1:0] regs_d [NUM_WORDS];
    ctl_t          ctl_q, ctl_d;

    logic [IDX_W-1:0] idx;
    logic             in_range, is_cmd, is_sts;
    logic             accept, reject;
    logic [DW-1:0]    sts_masked;

    sbcmd_decode #(.ADDR_W(ADDR_W), .NUM_WORDS(NUM_WORDS)) u_decode (
        .addr     (bus_addr),
        .idx      (idx),
        .in_range (in_range),
        .is_cmd   (is_cmd),
        .is_sts   (is_sts)
    );

    sbcmd_fire u_fire (
        .we       (bus_we),
        .hit_cmd  (is_cmd),
        .fire_bit (bus_wdata[0]),
        .pending  (regs_q[W_STS] != '0),
        .accept   (accept),
        .reject   (reject)
    );

    always_comb begin
        regs_d     = regs_q;
        ctl_d      = ctl_q;
        ctl_d.err  = reject;
        sts_masked = regs_q[W_EN] & DONE_MASK;
        if (accept) begin
            regs_d[W_TXBUF] = DONE_CODE;
            regs_d[W_RXBUF] = DONE_CODE;
            regs_d[W_STS]   = sts_masked;
            if (sts_masked != '0) begin
                ctl_d.irq = 1'b1;
            end
        end else if (bus_we && in_range && !is_cmd) begin
            if (is_sts) begin
                regs_d[W_STS] = regs_q[W_STS] & ~bus_wdata;
                if (regs_d[W_STS] == '0) begin
                    ctl_d.irq = 1'b0;
                end
            end else begin
                regs_d[idx] = bus_wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_WORDS; i++) begin
                regs_q[i] <= '0;
            end
            ctl_q <= '0;
        end else begin
            regs_q <= regs_d;
            ctl_q  <= ctl_d;
        end
    end

    always_comb begin
        bus_rdata = (in_range && !is_cmd) ? regs_q[idx] : '0;
    end

    assign irq_o       = ctl_q.irq;
    assign proto_err_o = ctl_q.err;

    // R3: completion code present in both buffers after an accepted fire
    a_r3_done_code: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (regs_q[W_TXBUF] == DONE_CODE) && (regs_q[W_RXBUF] == DONE_CODE));

    // R6: a refused fire flags an error and leaves the status untouched
    a_r6_reject_flag: assert property (@(posedge clk) disable iff (!rst_n)
        reject |=> proto_err_o && $stable(regs_q[W_STS]) && $stable(regs_q[W_TXBUF]));

    // R10: the interrupt level follows a nonzero status
    a_r10_irq_level: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == (regs_q[W_STS] != '0));

    // R1: the command word never reads back anything
    a_r1_cmd_zero: assert property (@(posedge clk) disable iff (!rst_n)
        is_cmd |-> bus_rdata == '0);

    // R2: a command write without the fire bit raises no error
    a_r2_no_fire: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && is_cmd && !bus_wdata[0]) |=> !proto_err_o);
endmodule

// File: tb/test_sbcmd_regs.sv
module test_sbcmd_regs;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o, proto_err_o;

    int total = 0;
    int bad = 0;
    logic [31:0] m [16];
    logic        m_irq;

    always #(CLK_PERIOD/2) clk = ~clk;

    sbcmd_regs i_sbcmd_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o),
        .proto_err_o(proto_err_o)
    );

    function automatic logic [31:0] exp_read(input logic [7:0] a);
        int w = int'(a[7:2]);
        if (w >= 16 || w == 2) return 32'h0;
        return m[w];
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input string req, input logic [7:0] a);
        @(negedge clk);
        bus_we = 1'b0;
        bus_addr = a;
        #1;
        check(req, bus_rdata, exp_read(a));
    endtask

    // write, update the model, check the outputs in the cycle after
    task automatic wr(input string req, input logic [7:0] a, input logic [31:0] d);
        int w = int'(a[7:2]);
        logic exp_err = 1'b0;
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        if (w < 16) begin
            if (w == 2) begin
                if (d[0]) begin
                    if (m[7] != 0) exp_err = 1'b1;
                    else begin
                        m[8] = 32'h40; m[12] = 32'h40;
                        m[7] = m[6] & 32'h1;
                        if (m[7] != 0) m_irq = 1'b1;
                    end
                end
            end else if (w == 7) begin
                m[7] = m[7] & ~d;
                if (m[7] == 0) m_irq = 1'b0;
            end else m[w] = d;
        end
        @(negedge clk);
        bus_we = 1'b0;
        check({req, " err"}, {31'h0, proto_err_o}, {31'h0, exp_err});
        check({req, " irq"}, {31'h0, irq_o}, {31'h0, m_irq});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int unsigned seed_dummy;
        seed_dummy = $urandom(32'd4242);
        for (int i = 0; i < 16; i++) m[i] = '0;
        m_irq = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R9 reset state
        for (int i = 0; i < 16; i++) rd("R9", 8'(i*4));
        check("R9 irq", {31'h0, irq_o}, 32'h0);
        check("R9 err", {31'h0, proto_err_o}, 32'h0);

        // R2 command without fire bit
        wr("R2", 8'h08, 32'hFFFF_FFFE);
        rd("R2", 8'h20); rd("R2", 8'h1C);
        // R1 command reads zero
        rd("R1", 8'h08);
        // R3/R4 fire with enable clear: code loaded, no interrupt
        wr("R4", 8'h08, 32'h1);
        rd("R3", 8'h20); rd("R3", 8'h30); rd("R4", 8'h1C);
        // R8 low address bits ignored
        wr("R8", 8'h1B, 32'hFFFF_FFFF);
        rd("R8", 8'h18);
        wr("R8", 8'h21, 32'h1234_5678);
        wr("R8", 8'h32, 32'h9ABC_DEF0);
        // R4 fire with enable set
        wr("R4", 8'h08, 32'h1);
        rd("R4", 8'h1C); rd("R3", 8'h20); rd("R3", 8'h30);
        // R6 fire refused while pending
        wr("R8", 8'h20, 32'hCAFE_0001);
        wr("R6", 8'h08, 32'h1);
        rd("R6", 8'h20); rd("R6", 8'h1C);
        // R5/R10 clear with zero mask keeps irq
        wr("R10", 8'h1C, 32'h0);
        wr("R5", 8'h1C, 32'hFFFF_FFFE);
        rd("R5", 8'h1C);
        wr("R5", 8'h1C, 32'h1);
        rd("R5", 8'h1C);
        // R7 out of range
        wr("R7", 8'h40, 32'hDEAD_BEEF);
        wr("R7", 8'hFC, 32'hDEAD_BEEF);
        rd("R7", 8'h40); rd("R7", 8'h00); rd("R7", 8'h3C);

        // constrained random traffic
        for (int n = 0; n < 400; n++) begin
            logic [7:0]  a;
            logic [31:0] d;
            int unsigned pick = $urandom % 8;
            if (pick == 0) a = 8'($urandom % 192) + 8'h40;
            else if (pick == 1) a = 8'h08 | 8'($urandom % 4);
            else if (pick == 2) a = 8'h1C;
            else a = 8'($urandom % 64);
            d = $urandom;
            if (pick == 2 && ($urandom % 2) == 1) d = 32'h1;
            wr("R8 rnd", a, d);
            rd("R8 rnd", a);
            if (n % 50 == 0)
                for (int i = 0; i < 16; i++) rd("R7 sweep", 8'(i*4));
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule